// File: doc/BRIEF.md
# Microcoded Control Sequencer for a Multicycle Datapath

This block steers a small multicycle processor datapath that handles five instruction classes: register-register ALU operations, OR with an immediate, word load, word store and branch on equal. It has no hand-written next-state case. A micro-program counter indexes a table of microinstructions. Each table word carries the datapath enables and selects, plus a two-bit field that picks the next micro-address. The three choices for the next micro-address are address zero, a target looked up from the instruction opcode, or the current address plus one.

The instruction register supplies the opcode and the datapath comparator supplies the equality flag. The sequencer returns the enables and selects one microinstruction at a time. The table is read synchronously, addressed by the next micro-address, so every output except the branch select comes straight from a register. The branch select is the registered branch field ANDed with the live equality flag. An opcode that has no table entry sends the sequencer back to instruction fetch and raises a one-cycle flag.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after the clock edge on which it is first sampled high, every enable and select output is 0. The first clock edge that samples `rst` low makes the following cycle an instruction fetch.
- R2: A fetch cycle asserts only `ir_wr` and `mem_rd`. The cycle after every fetch is a decode cycle that asserts only `ab_ld`.
- R3: Opcode 000000 is the register-register class. It runs an execute cycle (`alu_op`=10 meaning function field, `alu_src`=0 meaning register B, `s_ld`=1). It then runs a write-back cycle (`rf_wr`=1, `rf_dst`=1 meaning rd, `m2r`=0, `pc_wr`=1, `pc_sel`=0 meaning PC+4) and then a fetch.
- R4: Opcode 001101 is OR-immediate. It runs an execute cycle (`alu_op`=01 meaning OR, `alu_src`=1 meaning immediate, `s_ld`=1). It then runs a write-back cycle (`rf_wr`=1, `rf_dst`=0 meaning rt, `m2r`=0, `pc_wr`=1) and then a fetch.
- R5: Opcode 100011 is load word. It runs an address cycle (`alu_op`=00 meaning add, `alu_src`=1, `s_ld`=1), then a memory cycle (`mem_rd`=1, `m_ld`=1), then a write-back cycle (`rf_wr`=1, `rf_dst`=0, `m2r`=1, `pc_wr`=1), then a fetch.
- R6: Opcode 101011 is store word. It runs an address cycle (`alu_op`=00, `alu_src`=1, `s_ld`=1), then a memory cycle (`mem_wr`=1, `pc_wr`=1), then a fetch.
- R7: Opcode 000100 is branch on equal. It takes one cycle with `pc_wr`=1, in which `pc_sel` follows `br_eq` (1 selects the branch target, 0 selects PC+4), and then a fetch. In every other cycle `pc_sel` is 0, whatever the value of `br_eq`.
- R8: Any other opcode, seen in a decode cycle, makes the next cycle a fetch. `illegal_op` is 1 for exactly that one fetch cycle and 0 in every other cycle.
- R9: The opcode is sampled only in the decode cycle. Changing it in any other cycle leaves the outputs unchanged.
- R10: `mem_rd` and `mem_wr` are never 1 together. No write enable stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W (6) | Opcode field of the instruction register |
| br_eq | input | 1 | Equality flag from the datapath comparator |
| ir_wr | output | 1 | Load the instruction register |
| pc_wr | output | 1 | Write the PC |
| pc_sel | output | 1 | 1 selects the branch target for the PC, 0 selects PC+4 |
| ab_ld | output | 1 | Load operand registers A and B |
| alu_op | output | 2 | 00 add, 01 OR, 10 function field |
| alu_src | output | 1 | ALU second operand: 0 register B, 1 extended immediate |
| s_ld | output | 1 | Load the ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| m_ld | output | 1 | Load the memory data register |
| rf_wr | output | 1 | Register file write |
| rf_dst | output | 1 | Destination register: 0 rt, 1 rd |
| m2r | output | 1 | Write-back source: 0 ALU result, 1 memory data |
| illegal_op | output | 1 | One-cycle flag for an opcode with no table entry |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any check matters. They also assume that the opcode is stable from the decode cycle through its closing clock edge, because the dispatch lookup is combinational from that input. The stimulus therefore changes `opcode` and `br_eq` only at falling edges. It puts a new opcode in place during the decode cycle, and puts junk values on the opcode only in cycles where the sequencer must ignore it. The equality flag is allowed to move freely, since only the branch cycle should respond to it.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    NXT_ZERO = 2'b00,
    NXT_DISP = 2'b01,
    NXT_INC  = 2'b10
  } nxt_sel_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_OR   = 2'b01,
    ALU_FUNC = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic     ir_wr;
    logic     pc_wr;
    logic     branch;
    logic     ab_ld;
    alu_op_e  alu_op;
    logic     alu_src;
    logic     s_ld;
    logic     mem_rd;
    logic     mem_wr;
    logic     m_ld;
    logic     rf_wr;
    logic     rf_dst;
    logic     m2r;
    nxt_sel_e nxt;
  } uword_t;

  localparam int UWORD_W = $bits(uword_t);

  // micro-addresses
  localparam int UA_FETCH  = 0;
  localparam int UA_DECODE = 1;
  localparam int UA_BEQ    = 3;
  localparam int UA_RR_EX  = 4;
  localparam int UA_RR_WB  = 5;
  localparam int UA_OR_EX  = 6;
  localparam int UA_OR_WB  = 7;
  localparam int UA_LD_EA  = 8;
  localparam int UA_LD_MEM = 9;
  localparam int UA_LD_WB  = 10;
  localparam int UA_ST_EA  = 11;
  localparam int UA_ST_MEM = 12;

  // opcodes
  localparam logic [5:0] OPC_RR  = 6'b000000;
  localparam logic [5:0] OPC_BEQ = 6'b000100;
  localparam logic [5:0] OPC_ORI = 6'b001101;
  localparam logic [5:0] OPC_LD  = 6'b100011;
  localparam logic [5:0] OPC_ST  = 6'b101011;

  function automatic uword_t ucode_word(input int addr);
    uword_t w;
    w = '0;
    case (addr)
      UA_FETCH: begin
        w.ir_wr = 1'b1; w.mem_rd = 1'b1; w.nxt = NXT_INC;
      end
      UA_DECODE: begin
        w.ab_ld = 1'b1; w.nxt = NXT_DISP;
      end
      UA_BEQ: begin
        w.pc_wr = 1'b1; w.branch = 1'b1;
      end
      UA_RR_EX: begin
        w.alu_op = ALU_FUNC; w.s_ld = 1'b1; w.nxt = NXT_INC;
      end
      UA_RR_WB: begin
        w.rf_wr = 1'b1; w.rf_dst = 1'b1; w.pc_wr = 1'b1;
      end
      UA_OR_EX: begin
        w.alu_op = ALU_OR; w.alu_src = 1'b1; w.s_ld = 1'b1; w.nxt = NXT_INC;
      end
      UA_OR_WB: begin
        w.rf_wr = 1'b1; w.pc_wr = 1'b1;
      end
      UA_LD_EA, UA_ST_EA: begin
        w.alu_op = ALU_ADD; w.alu_src = 1'b1; w.s_ld = 1'b1; w.nxt = NXT_INC;
      end
      UA_LD_MEM: begin
        w.mem_rd = 1'b1; w.m_ld = 1'b1; w.nxt = NXT_INC;
      end
      UA_LD_WB: begin
        w.rf_wr = 1'b1; w.m2r = 1'b1; w.pc_wr = 1'b1;
      end
      UA_ST_MEM: begin
        w.mem_wr = 1'b1; w.pc_wr = 1'b1;
      end
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OP_W  = 6,
  parameter int UPC_W = 4
) (
  input  logic [OP_W-1:0]  opcode,
  output logic [UPC_W-1:0] target,
  output logic             hit
);

  always_comb begin
    hit    = 1'b1;
    target = '0;
    case (opcode)
      OP_W'(OPC_RR):  target = UPC_W'(UA_RR_EX);
      OP_W'(OPC_BEQ): target = UPC_W'(UA_BEQ);
      OP_W'(OPC_ORI): target = UPC_W'(UA_OR_EX);
      OP_W'(OPC_LD):  target = UPC_W'(UA_LD_EA);
      OP_W'(OPC_ST):  target = UPC_W'(UA_ST_EA);
      default:        hit    = 1'b0;
    endcase
  end

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int UPC_W = 4
) (
  input  logic [UPC_W-1:0] upc,
  input  nxt_sel_e         sel,
  input  logic [UPC_W-1:0] disp_tgt,
  input  logic             disp_hit,
  output logic [UPC_W-1:0] upc_nxt,
  output logic             bad_op
);

  always_comb begin
    upc_nxt = '0;
    bad_op  = 1'b0;
    case (sel)
      NXT_INC:  upc_nxt = upc + UPC_W'(1);
      NXT_DISP: begin
        if (disp_hit) upc_nxt = disp_tgt;
        else          bad_op  = 1'b1;
      end
      default:  upc_nxt = '0;
    endcase
  end

endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int UPC_W = 4,
  localparam int DEPTH = 1 << UPC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [UPC_W-1:0] raddr,
  output uword_t           q
);

  logic [UWORD_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = ucode_word(i);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= uword_t'(mem[raddr]);
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int OP_W  = 6,
  parameter int UPC_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            br_eq,
  output logic            ir_wr,
  output logic            pc_wr,
  output logic            pc_sel,
  output logic            ab_ld,
  output logic [1:0]      alu_op,
  output logic            alu_src,
  output logic            s_ld,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            m_ld,
  output logic            rf_wr,
  output logic            rf_dst,
  output logic            m2r,
  output logic            illegal_op
);

  logic [UPC_W-1:0] upc_q;
  logic [UPC_W-1:0] upc_nxt;
  logic [UPC_W-1:0] disp_tgt;
  logic             disp_hit;
  logic             bad_op;
  logic             ill_q;
  uword_t           word_q;

  useq_dispatch #(.OP_W(OP_W), .UPC_W(UPC_W)) u_disp (
    .opcode (opcode),
    .target (disp_tgt),
    .hit    (disp_hit)
  );

  useq_next #(.UPC_W(UPC_W)) u_next (
    .upc      (upc_q),
    .sel      (word_q.nxt),
    .disp_tgt (disp_tgt),
    .disp_hit (disp_hit),
    .upc_nxt  (upc_nxt),
    .bad_op   (bad_op)
  );

  // table is read with the next address so the word lines up with upc_q
  useq_store #(.UPC_W(UPC_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .raddr (upc_nxt),
    .q     (word_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upc_q <= '0;
      ill_q <= 1'b0;
    end else begin
      upc_q <= upc_nxt;
      ill_q <= bad_op;
    end
  end

  assign ir_wr      = word_q.ir_wr;
  assign pc_wr      = word_q.pc_wr;
  assign pc_sel     = word_q.branch & br_eq;
  assign ab_ld      = word_q.ab_ld;
  assign alu_op     = word_q.alu_op;
  assign alu_src    = word_q.alu_src;
  assign s_ld       = word_q.s_ld;
  assign mem_rd     = word_q.mem_rd;
  assign mem_wr     = word_q.mem_wr;
  assign m_ld       = word_q.m_ld;
  assign rf_wr      = word_q.rf_wr;
  assign rf_dst     = word_q.rf_dst;
  assign m2r        = word_q.m2r;
  assign illegal_op = ill_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(ir_wr || pc_wr || ab_ld || s_ld || mem_rd || mem_wr || m_ld || rf_wr));

  // R2
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (ab_ld && !ir_wr));

  // R2
  pc_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    pc_wr |=> ir_wr);

  // R8
  illegal_at_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> ir_wr);

  // R8
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_op |=> !illegal_op);

  // R10
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R10
  rf_once_chk: assert property (@(posedge clk) disable iff (rst)
    rf_wr |=> !rf_wr);

  // R10
  mem_wr_once_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);

endmodule

// File: tb/test_useq_ctrl.sv
module test_useq_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b000000;
  logic       br_eq = 1'b0;
  logic       ir_wr, pc_wr, pc_sel, ab_ld, alu_src, s_ld, mem_rd, mem_wr;
  logic       m_ld, rf_wr, rf_dst, m2r, illegal_op;
  logic [1:0] alu_op;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  useq_ctrl i_useq_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .br_eq(br_eq),
    .ir_wr(ir_wr), .pc_wr(pc_wr), .pc_sel(pc_sel), .ab_ld(ab_ld),
    .alu_op(alu_op), .alu_src(alu_src), .s_ld(s_ld), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .m_ld(m_ld), .rf_wr(rf_wr), .rf_dst(rf_dst),
    .m2r(m2r), .illegal_op(illegal_op)
  );

  // ir pc sel ab | op(2) | src sld mrd mwr mld rfw dst m2r
  logic [13:0] obs;
  assign obs = {ir_wr, pc_wr, pc_sel, ab_ld, alu_op, alu_src, s_ld,
                mem_rd, mem_wr, m_ld, rf_wr, rf_dst, m2r};

  localparam logic [13:0] W_IDLE   = 14'b0_0_0_0_00_0_0_0_0_0_0_0_0;
  localparam logic [13:0] W_FETCH  = 14'b1_0_0_0_00_0_0_1_0_0_0_0_0;
  localparam logic [13:0] W_DECODE = 14'b0_0_0_1_00_0_0_0_0_0_0_0_0;
  localparam logic [13:0] W_RR_EX  = 14'b0_0_0_0_10_0_1_0_0_0_0_0_0;
  localparam logic [13:0] W_RR_WB  = 14'b0_1_0_0_00_0_0_0_0_0_1_1_0;
  localparam logic [13:0] W_OR_EX  = 14'b0_0_0_0_01_1_1_0_0_0_0_0_0;
  localparam logic [13:0] W_RT_WB  = 14'b0_1_0_0_00_0_0_0_0_0_1_0_0;
  localparam logic [13:0] W_EA     = 14'b0_0_0_0_00_1_1_0_0_0_0_0_0;
  localparam logic [13:0] W_LD_MEM = 14'b0_0_0_0_00_0_0_1_0_1_0_0_0;
  localparam logic [13:0] W_LD_WB  = 14'b0_1_0_0_00_0_0_0_0_0_1_0_1;
  localparam logic [13:0] W_ST_MEM = 14'b0_1_0_0_00_0_0_0_1_0_0_0_0;
  localparam logic [13:0] W_BR_TK  = 14'b0_1_1_0_00_0_0_0_0_0_0_0_0;
  localparam logic [13:0] W_BR_NT  = 14'b0_1_0_0_00_0_0_0_0_0_0_0_0;
  localparam logic [5:0]  OP_JUNK  = 6'b111111;

  task automatic check(input string tag, input logic [13:0] exp);
    n_chk++;
    if (obs !== exp) begin
      n_err++;
      $display("FAIL %s: outputs %b expected %b", tag, obs, exp);
    end
  endtask

  task automatic check_ill(input string tag, input logic exp);
    n_chk++;
    if (illegal_op !== exp) begin
      n_err++;
      $display("FAIL %s: illegal_op %b expected %b", tag, illegal_op, exp);
    end
  endtask

  task automatic step(input string tag, input logic [13:0] exp);
    @(posedge clk);
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 outputs during reset", W_IDLE);
    check_ill("R1 flag during reset", 1'b0);
    rst = 1'b0;
    step("R1 first cycle after release is fetch", W_FETCH);
  endtask

  task automatic t_rtype();
    opcode = 6'b000000;
    br_eq  = 1'b1;
    step("R2 decode", W_DECODE);
    step("R3 execute", W_RR_EX);
    opcode = OP_JUNK;
    step("R3 write-back, R7 pc_sel low with br_eq high", W_RR_WB);
    step("R3 back to fetch", W_FETCH);
    check_ill("R8 no flag after valid opcode", 1'b0);
    br_eq = 1'b0;
  endtask

  task automatic t_ori();
    opcode = 6'b001101;
    step("R2 decode", W_DECODE);
    step("R4 execute", W_OR_EX);
    step("R4 write-back", W_RT_WB);
    step("R4 back to fetch", W_FETCH);
  endtask

  task automatic t_load();
    opcode = OP_JUNK;
    step("R9 decode unaffected by fetch-cycle opcode", W_DECODE);
    opcode = 6'b100011;
    step("R5 address", W_EA);
    opcode = 6'b101011;
    br_eq  = 1'b1;
    step("R5 R9 memory read ignores later opcode", W_LD_MEM);
    step("R5 write-back", W_LD_WB);
    step("R5 back to fetch", W_FETCH);
    check_ill("R9 no flag from junk fetch opcode", 1'b0);
    br_eq = 1'b0;
  endtask

  task automatic t_store();
    opcode = 6'b101011;
    step("R2 decode", W_DECODE);
    step("R6 address", W_EA);
    step("R6 R10 memory write alone", W_ST_MEM);
    step("R6 back to fetch", W_FETCH);
  endtask

  task automatic t_branch(input logic eq);
    opcode = 6'b000100;
    br_eq  = eq;
    step("R2 decode", W_DECODE);
    step(eq ? "R7 taken" : "R7 not taken", eq ? W_BR_TK : W_BR_NT);
    step("R7 back to fetch", W_FETCH);
    br_eq = 1'b0;
  endtask

  task automatic t_illegal();
    opcode = 6'b010101;
    step("R2 decode", W_DECODE);
    step("R8 illegal returns to fetch", W_FETCH);
    check_ill("R8 flag raised", 1'b1);
    opcode = 6'b000100;
    step("R8 decode after illegal", W_DECODE);
    check_ill("R8 flag lasts one cycle", 1'b0);
    step("R7 not taken after illegal", W_BR_NT);
    step("R7 back to fetch", W_FETCH);
  endtask

  task automatic t_mid_reset();
    opcode = 6'b100011;
    step("R2 decode", W_DECODE);
    step("R5 address", W_EA);
    rst = 1'b1;
    step("R1 reset mid-instruction clears outputs", W_IDLE);
    rst = 1'b0;
    step("R1 fetch after mid reset", W_FETCH);
    check_ill("R1 flag clear after reset", 1'b0);
  endtask

  initial begin
    t_reset();
    t_rtype();
    t_ori();
    t_load();
    t_store();
    t_branch(1'b1);
    t_branch(1'b0);
    t_illegal();
    t_mid_reset();
    t_rtype();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule